// File: doc/BRIEF.md
# Sixteen-bit Adder with Status Flags

This unit performs the add step of a 16-bit data path. Each accepted operation sums a base operand with a source operand. The source is either a full register value or a short unsigned literal taken from the instruction word. The unit produces a result, the register index it should be written to, and a write strobe. It also updates an internal five-bit flag register: carry, zero, signed overflow, negative and nibble carry.

The result, destination index, write strobe, done pulse and new flags all appear together, one clock after the valid cycle. The flags stay as they are in any cycle with no operation. A byte-width mode, chosen by one bit of the instruction word, does three things:
- it narrows the literal,
- it truncates the result to its low byte,
- it moves the carry, overflow and sign flags down to the byte boundary.

The surrounding pipeline reads the base operand from its register file and presents it at the same time as the instruction word. It then writes `res_data` back at `res_dst` when `res_we` is high.

Top module: `wadd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `flags_out`, `res_data`, `res_dst`, `done` and `res_we` all zero.
- R2: In word mode (instruction bit 14 clear), `res_data` equals (base + source) mod 2^16 in the cycle after `op_valid` is sampled high. `done` and `res_we` are high in that same cycle.
- R3: With `lit_form` high, the source is a literal from the instruction word and `src_val` is ignored. The literal is bits 13:4, zero-extended, when bit 14 is clear. It is bits 11:4 when bit 14 is set, and bits 13:12 are then ignored. The destination is bits 3:0. With `lit_form` low, the destination is bits 10:7.
- R4: `flags_out[1]` (zero) is set exactly when the written result is zero.
- R5: `flags_out[0]` (carry) is the carry out of the top bit: bit 15 in word mode, bit 7 in byte mode.
- R6: `flags_out[4]` (digit carry) is the carry out of the low nibble, from bit 3 into bit 4.
- R7: `flags_out[2]` (overflow) is set when both operands share a sign bit and the result's sign bit differs from it. The sign bit is bit 15 in word mode and bit 7 in byte mode.
- R8: `flags_out[3]` (negative) equals the result's sign bit: bit 15 in word mode, bit 7 in byte mode.
- R9: In byte mode (instruction bit 14 set), only the low bytes of both operands are added. `res_data[7:0]` is their 8-bit sum and `res_data[15:8]` is zero.
- R10: In a cycle after `op_valid` was sampled low, `done` and `res_we` are low. `flags_out`, `res_data` and `res_dst` hold their previous values.
- R11: Every operation rewrites all five flags together, so flags set by an earlier operation are cleared when the new sum does not produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An add is presented this cycle |
| lit_form | input | 1 | 1: source is the instruction literal; 0: source is `src_val` |
| insn_word | input | 15 | Instruction bits 14:0 (byte mode, literal, destination fields) |
| base_val | input | 16 | Base operand |
| src_val | input | 16 | Register source operand |
| res_data | output | 16 | Registered result |
| res_dst | output | 4 | Destination register index of the result |
| res_we | output | 1 | Result write strobe |
| flags_out | output | 5 | Flags {DC, N, OV, Z, C}, bit 0 = C |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker runs every cycle and checks these relations at the ports:
- the clearing effect of reset;
- that `done` and `res_we` follow a valid cycle by exactly one clock;
- that the flags hold across idle cycles;
- that the zero and negative flags agree with the result actually written;
- that the upper byte is zero after a byte operation.

The arithmetic flags are checked only by the bench: carry, nibble carry and overflow depend on the operands, which the ports no longer show. The same holds for literal extraction and the ignored instruction bits. The bench sweeps corner-value operand pairs in both widths, every word and byte literal, and a long run of random operations, and compares each against an arithmetic model.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  // Flag vector layout, LSB first: C, Z, OV, N, DC
  typedef struct packed {
    logic dc;
    logic n;
    logic ov;
    logic z;
    logic c;
  } wadd_flags_t;

  localparam int FLAG_CNT = $bits(wadd_flags_t);
endpackage

// File: rtl/wadd_opsel.sv
module wadd_opsel #(
  parameter int DATA_W   = 16,
  parameter int LIT_W    = 10,
  parameter int LITB_W   = 8,
  parameter int BYTE_BIT = 14,
  parameter int LIT_LSB  = 4,
  parameter int DST_W    = 4,
  parameter int LDST_LSB = 0,
  parameter int RDST_LSB = 7
) (
  input  logic              lit_form,
  input  logic [BYTE_BIT:0] insn,
  input  logic [DATA_W-1:0] src_reg,
  output logic [DATA_W-1:0] src_op,
  output logic              byte_op,
  output logic [DST_W-1:0]  dst_idx
);
  logic [LIT_W-1:0]  lit_wide;
  logic [LITB_W-1:0] lit_narrow;

  assign lit_wide   = insn[LIT_LSB +: LIT_W];
  assign lit_narrow = insn[LIT_LSB +: LITB_W];
  assign byte_op    = insn[BYTE_BIT];

  always_comb begin
    if (lit_form) begin
      src_op  = byte_op ? DATA_W'(lit_narrow) : DATA_W'(lit_wide);
      dst_idx = insn[LDST_LSB +: DST_W];
    end else begin
      src_op  = src_reg;
      dst_idx = insn[RDST_LSB +: DST_W];
    end
  end
endmodule

// File: rtl/wadd_core.sv
module wadd_core
  import wadd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              byte_op,
  output logic [DATA_W-1:0] sum_o,
  output wadd_flags_t       flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] wide_sum;
  logic [HALF_W:0] narrow_sum;
  logic            sa, sb, sr;

  assign wide_sum   = {1'b0, a} + {1'b0, b};
  assign narrow_sum = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]};

  always_comb begin
    if (byte_op) begin
      sum_o     = {{(DATA_W-HALF_W){1'b0}}, narrow_sum[HALF_W-1:0]};
      flags_o.c = narrow_sum[HALF_W];
      sa        = a[HALF_W-1];
      sb        = b[HALF_W-1];
      sr        = narrow_sum[HALF_W-1];
    end else begin
      sum_o     = wide_sum[DATA_W-1:0];
      flags_o.c = wide_sum[DATA_W];
      sa        = a[DATA_W-1];
      sb        = b[DATA_W-1];
      sr        = wide_sum[DATA_W-1];
    end
    flags_o.z  = (sum_o == '0);
    flags_o.n  = sr;
    flags_o.ov = (sa & sb & ~sr) | (~sa & ~sb & sr);
    // carry into bit NIB_W recovered from the sum and operand bits
    flags_o.dc = wide_sum[NIB_W] ^ a[NIB_W] ^ b[NIB_W];
  end
endmodule

// File: rtl/wadd_regs.sv
module wadd_regs
  import wadd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DST_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] sum_in,
  input  logic [DST_W-1:0]  dst_in,
  input  wadd_flags_t       flags_in,
  output logic [DATA_W-1:0] res_q,
  output logic [DST_W-1:0]  dst_q,
  output wadd_flags_t       flags_q,
  output logic              done_q,
  output logic              we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      dst_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      done_q <= load;
      we_q   <= load;
      if (load) begin
        res_q   <= sum_in;
        dst_q   <= dst_in;
        flags_q <= flags_in;
      end
    end
  end
endmodule

// File: rtl/wadd_unit.sv
module wadd_unit
  import wadd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NIB_W    = 4,
  parameter int LIT_W    = 10,
  parameter int LITB_W   = 8,
  parameter int BYTE_BIT = 14,
  parameter int LIT_LSB  = 4,
  parameter int DST_W    = 4,
  parameter int LDST_LSB = 0,
  parameter int RDST_LSB = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic                lit_form,
  input  logic [BYTE_BIT:0]   insn_word,
  input  logic [DATA_W-1:0]   base_val,
  input  logic [DATA_W-1:0]   src_val,
  output logic [DATA_W-1:0]   res_data,
  output logic [DST_W-1:0]    res_dst,
  output logic                res_we,
  output logic [FLAG_CNT-1:0] flags_out,
  output logic                done
);
  logic [DATA_W-1:0] src_sel;
  logic [DST_W-1:0]  dst_sel;
  logic              byte_sel;
  logic [DATA_W-1:0] sum_w;
  wadd_flags_t       flags_w;
  wadd_flags_t       flags_r;

  wadd_opsel #(
    .DATA_W(DATA_W), .LIT_W(LIT_W), .LITB_W(LITB_W), .BYTE_BIT(BYTE_BIT),
    .LIT_LSB(LIT_LSB), .DST_W(DST_W), .LDST_LSB(LDST_LSB), .RDST_LSB(RDST_LSB)
  ) u_opsel (
    .lit_form(lit_form), .insn(insn_word), .src_reg(src_val),
    .src_op(src_sel), .byte_op(byte_sel), .dst_idx(dst_sel)
  );

  wadd_core #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_core (
    .a(base_val), .b(src_sel), .byte_op(byte_sel),
    .sum_o(sum_w), .flags_o(flags_w)
  );

  wadd_regs #(.DATA_W(DATA_W), .DST_W(DST_W)) u_regs (
    .clk(clk), .rst(rst), .load(op_valid),
    .sum_in(sum_w), .dst_in(dst_sel), .flags_in(flags_w),
    .res_q(res_data), .dst_q(res_dst), .flags_q(flags_r),
    .done_q(done), .we_q(res_we)
  );

  assign flags_out = flags_r;
endmodule

// File: rtl/wadd_chk.sv
module wadd_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              byte_sel,
  input logic [DATA_W-1:0] res_data,
  input logic              res_we,
  input logic [4:0]        flags_out,
  input logic              done
);
  localparam int HALF_W = DATA_W / 2;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_out == '0 && !done && !res_we && res_data == '0));

  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (done && res_we));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!done && !res_we && $stable(flags_out) && $stable(res_data)));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (flags_out[1] == (res_data == '0)));

  // R8
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (flags_out[3] == ($past(byte_sel) ? res_data[HALF_W-1] : res_data[DATA_W-1])));

  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && byte_sel) |=> (res_data[DATA_W-1:HALF_W] == '0));
endmodule

bind wadd_unit wadd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .byte_sel(byte_sel),
  .res_data(res_data), .res_we(res_we), .flags_out(flags_out), .done(done)
);

// File: tb/sim_wadd_unit.sv
module sim_wadd_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic        lit_form;
  logic [14:0] insn_word;
  logic [15:0] base_val, src_val;
  logic [15:0] res_data;
  logic [3:0]  res_dst;
  logic        res_we, done;
  logic [4:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wadd_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .lit_form(lit_form),
    .insn_word(insn_word), .base_val(base_val), .src_val(src_val),
    .res_data(res_data), .res_dst(res_dst), .res_we(res_we),
    .flags_out(flags_out), .done(done)
  );

  logic [15:0] corner [12] = '{16'h0000, 16'h0001, 16'h000F, 16'h0010,
                               16'h007F, 16'h0080, 16'h00FF, 16'h1234,
                               16'h7FFF, 16'h8000, 16'hFFF1, 16'hFFFF};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Arithmetic model: returns {flags[4:0], result[15:0]}; flags {DC,N,OV,Z,C}
  function automatic logic [20:0] model(input logic [15:0] b, input logic [15:0] s,
                                        input logic bm);
    logic [16:0] w;
    logic [8:0]  h;
    logic [4:0]  nib;
    logic [15:0] r;
    logic c, z, ov, n, dc, sa, sb;
    nib = {1'b0, b[3:0]} + {1'b0, s[3:0]};
    dc  = (nib > 5'd15);
    if (bm) begin
      h  = {1'b0, b[7:0]} + {1'b0, s[7:0]};
      r  = {8'h00, h[7:0]};
      c  = h[8];
      n  = h[7];
      sa = b[7]; sb = s[7];
    end else begin
      w  = {1'b0, b} + {1'b0, s};
      r  = w[15:0];
      c  = w[16];
      n  = w[15];
      sa = b[15]; sb = s[15];
    end
    z  = (r == 16'h0000);
    ov = (sa == sb) && (n != sa);
    return {dc, n, ov, z, c, r};
  endfunction

  task automatic run_op(input logic lf, input logic [14:0] ins,
                        input logic [15:0] b, input logic [15:0] s);
    logic [15:0] src_eff;
    logic [3:0]  dst_exp;
    logic [20:0] e;
    string rtag;
    src_eff = lf ? (ins[14] ? {8'h00, ins[11:4]} : {6'h00, ins[13:4]}) : s;
    dst_exp = lf ? ins[3:0] : ins[10:7];
    e = model(b, src_eff, ins[14]);
    rtag = ins[14] ? "R9" : (lf ? "R3" : "R2");
    @(negedge clk);
    op_valid = 1'b1; lit_form = lf; insn_word = ins; base_val = b; src_val = s;
    @(negedge clk);
    op_valid = 1'b0;
    chk(rtag, "result", res_data, e[15:0]);
    chk("R3", "dest", res_dst, dst_exp);
    chk("R2", "done", {done, res_we}, 2'b11);
    chk("R5", "carry", flags_out[0], e[16]);
    chk("R4", "zero", flags_out[1], e[17]);
    chk("R7", "overflow", flags_out[2], e[18]);
    chk("R8", "negative", flags_out[3], e[19]);
    chk("R6", "digit carry", flags_out[4], e[20]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0]  fsave;
    logic [15:0] rsave;
    rst = 1'b1; op_valid = 1'b0; lit_form = 1'b0; insn_word = '0;
    base_val = '0; src_val = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "flags after reset", flags_out, 5'h00);
    chk("R1", "strobes after reset", {done, res_we}, 2'b00);
    chk("R1", "result after reset", res_data, 16'h0000);
    rst = 1'b0;

    // Corner sweep, register form, word and byte
    for (int bm = 0; bm < 2; bm++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_op(1'b0, {bm[0], 3'($urandom), 4'(i + j), 7'($urandom)}, corner[i], corner[j]);

    // R3: every word literal, src_val driven with junk that must be ignored
    for (int l = 0; l < 1024; l++)
      run_op(1'b1, {1'b0, l[9:0], 4'(l)}, corner[l % 12], 16'($urandom));

    // R3/R9: every byte literal, bits 13:12 set as garbage
    for (int l = 0; l < 256; l++)
      run_op(1'b1, {1'b1, 2'b11, l[7:0], 4'(l + 3)}, corner[(l + 5) % 12], 16'($urandom));

    // Random mix
    for (int k = 0; k < 1500; k++)
      run_op(1'($urandom), 15'($urandom), 16'($urandom), 16'($urandom));

    // R11: flags set by one add are all replaced by the next
    run_op(1'b0, 15'h0000, 16'h8000, 16'h8000);
    chk("R11", "flag vector set", flags_out, 5'b00111);
    run_op(1'b0, 15'h0000, 16'h0001, 16'h0001);
    chk("R11", "flag vector cleared", flags_out, 5'b00000);
    run_op(1'b0, 15'h0000, 16'h000F, 16'h7FF1);
    chk("R11", "flag vector dc/ov/n", flags_out, 5'b11100);

    // R10: idle cycles with changing inputs leave everything held
    fsave = flags_out; rsave = res_data;
    for (int k = 0; k < 4; k++) begin
      base_val = 16'($urandom); src_val = 16'($urandom); insn_word = 15'($urandom);
      lit_form = 1'($urandom);
      @(negedge clk);
      chk("R10", "idle strobes", {done, res_we}, 2'b00);
      chk("R10", "idle flags", flags_out, fsave);
      chk("R10", "idle result", res_data, rsave);
    end

    // R1: mid-run reset clears non-zero state
    run_op(1'b0, 15'h0000, 16'hFFFF, 16'h0001);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "flags after mid-run reset", flags_out, 5'h00);
    chk("R1", "result after mid-run reset", res_data, 16'h0000);
    chk("R1", "strobes after mid-run reset", {done, res_we}, 2'b00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule